// File: doc/BRIEF.md
# SD Command Line Engine

This block is the host side of the single-bit SD command line. It runs in the card clock domain. After reset it holds the line high for a fixed initialisation period and then releases it. From then on it waits for a start pulse. The pulse carries a 40-bit command word and a 2-bit response mode. The block shifts the word out one bit per clock, appends a CRC7 and an end bit, and then releases the line.

When the mode asks for a reply, the block watches the line for the card's start bit. It then collects a short frame of 48 bits or a long frame of 136 bits. It checks the CRC and, for short replies, the command index. It signals completion with a one-clock pulse. The output-enable lets the surrounding logic share the pad between host and card. The pad itself sits outside the block.

Top module: `sdcmd_engine`

## Requirements
- R1: From the first clock edge with rst_n high, line_out is 1 and line_oe is 1 for INIT_CYCLES (65) clock edges, done and both flags are 0, and line_oe is 0 after edge 65.
- R2: In idle, a start sampled high at a clock edge loads cmd_word. Bit 39 appears on line_out right after that edge, with the lower bits following one per clock, MSB first. line_oe stays 1 throughout.
- R3: The 40 command bits are followed by 7 CRC bits, MSB first. The CRC uses x^7+x^3+1 with a zero start value over all 40 command bits. A single end bit of 1 follows, and line_oe falls on the edge after the end bit.
- R4: The resp_mode value latched at start selects the reply. Bit 0 set means a reply is expected, and bit 1 set means it is long. Value 1 is a 48-bit reply, value 3 is a 136-bit reply, and values 0 and 2 expect no reply.
- R5: With no reply expected, done pulses on the same edge that drops line_oe. crc_good, idx_good and resp_data are then 0.
- R6: While waiting for a reply, line_oe is 0. Any number of leading 1s on line_in is skipped, and the first 0 is taken as frame bit 0.
- R7: A short reply places frame bits 8..39 on resp_data[119:88], with the remaining bits 0. crc_good is 1 exactly when frame bits 40..46 equal the CRC7 of frame bits 0..39.
- R8: For a short reply, idx_good is 1 exactly when frame bits 2..7 equal cmd_word[37:32] of the command sent.
- R9: A long reply places frame bits 8..127 on resp_data. crc_good compares frame bits 128..134 with the CRC7 of frame bits 8..127 only, and idx_good is 1.
- R10: done is high for one clock, right after the edge that samples the end bit of the reply. resp_data and both flags are cleared when a start is accepted and otherwise hold their value.
- R11: A start pulse during initialisation, transmission, waiting or reception is ignored.
- R12: A start sampled on the edge right after done has been raised is accepted, and the new frame begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-clock request to send a command |
| resp_mode | input | 2 | Reply type for this command |
| cmd_word | input | 40 | Command frame body, MSB sent first |
| line_in | input | 1 | Sampled level of the command line |
| line_out | output | 1 | Level driven onto the command line |
| line_oe | output | 1 | Host drives the line when 1 |
| done | output | 1 | One-clock completion pulse |
| resp_data | output | 120 | Captured reply content |
| crc_good | output | 1 | Reply CRC matched |
| idx_good | output | 1 | Reply index matched (1 for long replies) |

## Verification
Two events can meet in one cycle: the completion pulse of one transfer and the start pulse of the next. The bench raises start in the very cycle it observes done. It then checks three things: the previous results were correct during that cycle, they clear on the same edge that launches the new frame, and the new frame starts one clock later. The opposite overlap is also exercised. A start arrives while the reply's later bits are still being sampled, or in the middle of the command. The bench judges it ignored because the frame in progress, its results and the idle line that follows are all unchanged.

// File: rtl/sdcmd_pkg.sv
// Shared constants and state encoding for the SD command line engine.
package sdcmd_pkg;
    localparam int CRC_W = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;   // x^7 + x^3 + 1

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_TXCMD,
        ST_TXCRC,
        ST_TXEND,
        ST_WAIT,
        ST_RX
    } sdcmd_state_e;
endpackage

// File: rtl/sdcmd_crc7.sv
// One-bit step of a serial CRC, MSB-first shift form.
// Assumes the caller holds the running value and applies one bit per call.
module sdcmd_crc7 #(
    parameter int W = 7,
    parameter logic [W-1:0] POLY = 7'h09
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;

    // next value: shift left, fold polynomial in on feedback
    always_comb begin
        fb    = bit_i ^ crc_i[W-1];
        crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/sdcmd_init_timer.sv
// Counts clocks after reset release and reports when the initialisation
// period is over. Assumes CYCLES >= 2; the flag holds once set.
module sdcmd_init_timer #(
    parameter int CYCLES = 65
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);
    localparam int TW = $clog2(CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q == LAST);

    // saturating count of clocks since reset release
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end

    // R1
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);
endmodule

// File: rtl/sdcmd_engine.sv
// Host engine for the serial SD command line.
// Sends a start-triggered command frame with CRC7 and end bit, releases the
// line, optionally collects a short or long reply and checks CRC and index.
// Assumes line_in is already synchronous to clk and the pad mux is outside.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int INIT_CYCLES = 65,
    parameter int CMD_W       = 40,
    parameter int RSP_W       = 120,
    parameter int HDR_W       = 8,
    parameter int SHORT_PAY   = 32,
    parameter int IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       resp_mode,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             line_in,
    output logic             line_out,
    output logic             line_oe,
    output logic             done,
    output logic [RSP_W-1:0] resp_data,
    output logic             crc_good,
    output logic             idx_good
);
    localparam int LONG_LEN  = HDR_W + RSP_W;
    localparam int SHORT_LEN = CMD_W;
    localparam int IDX_HI    = CMD_W - 3;
    localparam int CNT_W     = $clog2(LONG_LEN + CRC_W + 2);
    localparam logic [CNT_W-1:0] C_CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] C_CRC_LAST = CNT_W'(CRC_W - 1);
    localparam logic [CNT_W-1:0] C_HDR      = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] C_LONG     = CNT_W'(LONG_LEN);
    localparam logic [CNT_W-1:0] C_SHORT    = CNT_W'(SHORT_LEN);
    localparam logic [CNT_W-1:0] C_CRC      = CNT_W'(CRC_W);

    sdcmd_state_e         state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [CMD_W-1:0]     tx_sh;
    logic [CRC_W-1:0]     crc_q, crc_nx, rx_crc_q;
    logic [LONG_LEN-1:0]  rx_sh;
    logic [1:0]           mode_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 init_done, crc_bit;
    logic [CNT_W-1:0]     content_len, crc_end;
    logic                 accept, rx_last;

    sdcmd_init_timer #(.CYCLES(INIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .expired (init_done)
    );

    sdcmd_crc7 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i (crc_q),
        .bit_i (crc_bit),
        .crc_o (crc_nx)
    );

    // select CRC input bit and reply length decode
    always_comb begin
        crc_bit     = (state_q == ST_TXCMD) ? line_out : line_in;
        content_len = mode_q[1] ? C_LONG : C_SHORT;
        crc_end     = content_len + C_CRC;
        accept      = (state_q == ST_IDLE) && start;
        rx_last     = (state_q == ST_RX) && (cnt_q == crc_end);
    end

    // main sequencer: init, transmit, wait, receive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_INIT;
            line_oe   <= 1'b1;
            line_out  <= 1'b1;
            done      <= 1'b0;
            resp_data <= '0;
            crc_good  <= 1'b0;
            idx_good  <= 1'b0;
            cnt_q     <= '0;
            tx_sh     <= '0;
            crc_q     <= '0;
            rx_crc_q  <= '0;
            rx_sh     <= '0;
            mode_q    <= '0;
            idx_q     <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_INIT: if (init_done) begin
                    state_q <= ST_IDLE;
                    line_oe <= 1'b0;
                end
                ST_IDLE: if (start) begin
                    mode_q    <= resp_mode;
                    idx_q     <= cmd_word[IDX_HI -: IDX_W];
                    line_out  <= cmd_word[CMD_W-1];
                    tx_sh     <= {cmd_word[CMD_W-2:0], 1'b0};
                    line_oe   <= 1'b1;
                    crc_q     <= '0;
                    cnt_q     <= '0;
                    resp_data <= '0;
                    crc_good  <= 1'b0;
                    idx_good  <= 1'b0;
                    state_q   <= ST_TXCMD;
                end
                ST_TXCMD: begin
                    if (cnt_q == C_CMD_LAST) begin
                        line_out <= crc_nx[CRC_W-1];
                        crc_q    <= {crc_nx[CRC_W-2:0], 1'b0};
                        cnt_q    <= '0;
                        state_q  <= ST_TXCRC;
                    end else begin
                        crc_q    <= crc_nx;
                        line_out <= tx_sh[CMD_W-1];
                        tx_sh    <= {tx_sh[CMD_W-2:0], 1'b0};
                        cnt_q    <= cnt_q + 1'b1;
                    end
                end
                ST_TXCRC: begin
                    if (cnt_q == C_CRC_LAST) begin
                        line_out <= 1'b1;
                        state_q  <= ST_TXEND;
                    end else begin
                        line_out <= crc_q[CRC_W-1];
                        crc_q    <= {crc_q[CRC_W-2:0], 1'b0};
                        cnt_q    <= cnt_q + 1'b1;
                    end
                end
                ST_TXEND: begin
                    line_oe  <= 1'b0;
                    line_out <= 1'b1;
                    if (!mode_q[0]) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: if (!line_in) begin
                    state_q <= ST_RX;
                    cnt_q   <= CNT_W'(1);
                    crc_q   <= '0;
                    rx_sh   <= '0;
                end
                ST_RX: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q < content_len) begin
                        rx_sh <= {rx_sh[LONG_LEN-2:0], line_in};
                        if (!mode_q[1] || cnt_q >= C_HDR) crc_q <= crc_nx;
                    end else if (cnt_q < crc_end) begin
                        rx_crc_q <= {rx_crc_q[CRC_W-2:0], line_in};
                    end else begin
                        done     <= 1'b1;
                        state_q  <= ST_IDLE;
                        crc_good <= (rx_crc_q == crc_q);
                        if (mode_q[1]) begin
                            resp_data <= rx_sh[RSP_W-1:0];
                            idx_good  <= 1'b1;
                        end else begin
                            resp_data <= {rx_sh[SHORT_PAY-1:0], {(RSP_W-SHORT_PAY){1'b0}}};
                            idx_good  <= (rx_sh[IDX_HI -: IDX_W] == idx_q);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1
    init_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |-> (line_oe && line_out));
    // R2
    tx_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_TXCMD, ST_TXCRC, ST_TXEND}) |-> line_oe);
    // R3
    end_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TXEND) |=> !line_oe);
    // R5
    noresp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q[0]) |-> (!crc_good && !idx_good));
    // R6
    wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_WAIT, ST_RX}) |-> !line_oe);
    // R9
    long_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == 2'b11) |-> idx_good);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !rx_last) |=> ($stable(resp_data) && $stable(crc_good) && $stable(idx_good)));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_TXCMD, ST_TXCRC, ST_WAIT}) |=> (state_q != ST_IDLE));
endmodule

// File: tb/tb_sdcmd_engine.sv
`timescale 1ns/1ps
module tb_sdcmd_engine;
    localparam int INIT = 65;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   resp_mode = 2'b00;
    logic [39:0]  cmd_word = '0;
    logic         line_in = 1'b1;
    logic         line_out, line_oe, done, crc_good, idx_good;
    logic [119:0] resp_data;

    int  checks = 0;
    int  errors = 0;
    bit  chained = 1'b0;

    always #4 clk = ~clk;

    sdcmd_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .resp_mode(resp_mode),
        .cmd_word(cmd_word), .line_in(line_in), .line_out(line_out),
        .line_oe(line_oe), .done(done), .resp_data(resp_data),
        .crc_good(crc_good), .idx_good(idx_good)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] crc_of(input logic [135:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [39:0] mk_cmd(input int i);
        logic [5:0] cidx = (i % 3 == 0) ? 6'(i) : (6'(i) ^ 6'h15);
        return {2'b01, cidx, 32'(i) * 32'h2545F491 ^ 32'h5A5A0F0F};
    endfunction

    // one complete transfer; optional stray starts and chained next start
    task automatic xfer(input logic [39:0] cmd, input logic [1:0] md, input logic [127:0] content_in,
                        input bit bad, input int gap, input bit poke,
                        input bit chain, input logic [39:0] ncmd, input logic [1:0] nmd);
        logic [6:0]   ccrc = crc_of({96'b0, cmd}, 40);
        logic [127:0] content = content_in;
        logic [135:0] fr;
        logic [6:0]   rcrc;
        logic [119:0] exp_rsp;
        bit           exp_idx;
        int           total;
        bit           lng = md[1];
        if (!chained) begin
            start = 1'b1; cmd_word = cmd; resp_mode = md;
        end
        chained = 1'b0;
        @(negedge clk);
        start = 1'b0; cmd_word = ~cmd; resp_mode = ~md;
        // R10: results cleared on accepted start
        chk(resp_data == '0 && !crc_good && !idx_good, "R10 clear on start",
            {resp_data, crc_good, idx_good}, '0);
        for (int k = 0; k < 48; k++) begin
            logic e = (k < 40) ? cmd[39-k] : (k < 47) ? ccrc[46-k] : 1'b1;
            chk(line_oe === 1'b1 && line_out === e, (k < 40) ? "R2 cmd bit" : "R3 crc/end bit",
                {line_oe, line_out}, {1'b1, e});
            start = poke && (k == 20);   // R11 stray start during transmit
            if (k < 47) @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        chk(line_oe === 1'b0, "R3 oe drop after end bit", line_oe, 0);
        if (!md[0]) begin
            chk(done && !crc_good && !idx_good && resp_data == '0, "R4 R5 no-reply finish",
                {done, crc_good, idx_good, resp_data}, {1'b1, 122'b0});
            exp_rsp = '0; exp_idx = 1'b0; rcrc = '0;
        end else begin
            chk(!done, "R6 no done before reply", done, 0);
            if (lng) begin
                content[127:120] = 8'h3F;
                rcrc = crc_of({8'b0, content}, 120);
                total = 136;
                exp_rsp = content[119:0];
                exp_idx = 1'b1;
            end else begin
                content[127:40] = '0; content[39:38] = 2'b00;
                rcrc = crc_of({8'b0, content}, 40);
                total = 48;
                exp_rsp = {content[31:0], 88'b0};
                exp_idx = (content[37:32] == cmd[37:32]);
            end
            fr = lng ? {content, rcrc ^ {6'b0, bad}, 1'b1}
                     : {88'b0, content[39:0], rcrc ^ {6'b0, bad}, 1'b1};
            for (int g = 0; g < gap; g++) begin
                line_in = 1'b1;
                chk(line_oe === 1'b0 && !done, "R6 idle wait", {line_oe, done}, 0);
                @(negedge clk);
            end
            for (int b = total - 1; b >= 0; b--) begin
                line_in = fr[b];
                start = poke && (b == 3);   // R11 stray start during reply
                chk(line_oe === 1'b0 && !done, "R6 receive", {line_oe, done}, 0);
                @(negedge clk);
            end
            line_in = 1'b1; start = 1'b0;
            chk(done === 1'b1, "R10 done pulse", done, 1);
            chk(resp_data == exp_rsp, lng ? "R9 long data" : "R7 short data", resp_data, exp_rsp);
            chk(crc_good == !bad, lng ? "R9 long crc" : "R7 short crc", crc_good, !bad);
            chk(idx_good == exp_idx, lng ? "R9 long idx" : "R8 short idx", idx_good, exp_idx);
        end
        if (chain) begin
            // R12: start in the done cycle
            start = 1'b1; cmd_word = ncmd; resp_mode = nmd; chained = 1'b1;
        end else begin
            @(negedge clk);
            chk(!done && !line_oe, "R10 R11 single pulse, line idle", {done, line_oe}, 0);
            chk(resp_data == exp_rsp && crc_good == (md[0] && !bad) && idx_good == exp_idx,
                "R10 results hold", {resp_data, crc_good, idx_good},
                {exp_rsp, md[0] && !bad, exp_idx});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] cont;
        repeat (3) @(negedge clk);
        chk(line_oe && line_out && !done && !crc_good && !idx_good, "R1 reset state",
            {line_oe, line_out, done, crc_good, idx_good}, 5'b11000);
        rst_n = 1'b1;
        for (int i = 1; i <= INIT; i++) begin
            @(negedge clk);
            start = (i == 10);   // R11 start during init
            if (i < INIT) chk(line_oe && line_out, "R1 init drive", {line_oe, line_out}, 2'b11);
            else          chk(!line_oe, "R1 init release", line_oe, 0);
        end
        start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(!line_oe && !done, "R11 init start ignored", {line_oe, done}, 0);
        end

        // no-reply modes 0 and 2 (R4, R5)
        xfer(40'h4A_1234_5678, 2'b00, '0, 0, 0, 0, 0, '0, 2'b00);
        xfer(40'h7F_FFFF_FFFF, 2'b10, '0, 0, 0, 1, 1, mk_cmd(0), 2'b01);

        // short reply sweep over every index value (R7, R8)
        for (int i = 0; i < 64; i++) begin
            cont = {88'b0, 2'b00, 6'(i), 32'h9E3779B9 * 32'(i + 1)};
            xfer(mk_cmd(i), 2'b01, cont, (i % 5) == 4, i % 4, i == 10, i == 20, mk_cmd(i + 1), 2'b01);
        end

        // long replies (R9)
        for (int j = 0; j < 4; j++) begin
            cont = '0;
            for (int w = 0; w < 4; w++) cont[w*32 +: 32] = 32'h01234567 * 32'(j + w + 3);
            xfer(mk_cmd(j + 70), 2'b11, cont, j == 2, j + 1, j == 1, j == 3, 40'h40_0000_0000, 2'b00);
        end
        xfer(40'h40_0000_0000, 2'b00, '0, 0, 0, 0, 0, '0, 2'b00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule